// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static RAM whose address and control inputs pass through registers on the rising clock edge. Any sequence of reads and writes runs on consecutive cycles without dead cycles between them. Write data lags its address: by two cycles in pipelined mode and by one cycle in flow-through mode. A static strap picks the mode. In pipelined mode read data passes through an output register. In flow-through mode it is driven in the cycle after the address is captured.

A load cycle starts an access. An advance cycle continues the current burst of up to four beats, in linear or interleaved order. Each write is split into 9-bit bytes, and each byte has its own enable. Every enabled write byte is checked for parity, even or odd as selected, and a flag reports a failure. The data bus is modelled as separate input and output buses plus a drive enable. An asynchronous output enable can switch the drive off at any moment.

The block has no valid/ready handshake and never applies back-pressure. The array accepts an access on every clock. The caller must present write data in the cycle given by the mode and take read data in the cycle the drive enable marks.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises with no access loaded, `rdata_en` and `par_err` are 0.
- R2: A load cycle (`adv`=0) selects an access only when all `chip_en` bits are 1. Otherwise it is a deselect: it writes nothing and drives no data.
- R3: In pipelined mode (`pipe_mode`=1), a read captured at edge k drives `rdata_en`=1 and its data from edge k+1 until edge k+2.
- R4: In flow-through mode (`pipe_mode`=0), a read captured at edge k drives `rdata_en`=1 and its data from edge k until edge k+1.
- R5: For a write captured at edge k, `wdata` is sampled at edge k+2 in pipelined mode and at edge k+1 in flow-through mode.
- R6: Byte b of the data word is bits 9b+8 down to 9b. A write changes only the bytes whose `byte_en` bit was 1 in its address cycle.
- R7: Reads and writes can be mixed freely on consecutive cycles. A read returns the newest data for its address, including a write whose data arrives in the same edge as the read's output load, merged byte by byte.
- R8: An advance cycle (`adv`=1) repeats the operation of the current burst, ignores `chip_en` and steps a 2-bit beat counter that wraps modulo 4. Advancing after a deselect remains a deselect.
- R9: `burst_ilv` is latched on load. When it is 0, the low two address bits of beat n are (start + n) mod 4. When it is 1, they are start XOR n. The upper address bits stay fixed for the whole burst.
- R10: `oe_n`=1 forces `rdata_en` and `rdata` to 0 at once, without waiting for a clock edge.
- R11: When an enabled byte's 9-bit XOR differs from `par_odd` at its data-sampling edge, `par_err` is 1 for the following cycle. The byte is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, used on load cycles |
| we | input | 1 | 1 = write, 0 = read, used on load cycles |
| byte_en | input | BYTES | Per-byte write enables for this beat |
| chip_en | input | CE_N | Chip enables, all must be 1 to select a load cycle |
| adv | input | 1 | 1 = advance the burst, 0 = load a new access |
| burst_ilv | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| pipe_mode | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| par_odd | input | 1 | Static parity select: 0 even, 1 odd |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 9*BYTES | Late write data |
| rdata | output | 9*BYTES | Read data, 0 while not driven |
| rdata_en | output | 1 | Data bus drive enable |
| par_err | output | 1 | Write parity failure flag |

## Verification
The bench alternates reads and writes to a single address with partial byte enables in both modes. A design that lacks the late-write bypass, or that merges the wrong bytes, returns stale array contents there. It runs four-beat and longer bursts in both orders from unaligned start addresses, and advances after deselects. A wrong beat counter, a wrap error, or a burst that resurrects after a deselect shows up as wrong data or as spurious drive. It also pulses the output enable between clock edges and injects bad parity under both parity senses, which exposes a synchronous output gate or an inverted parity check.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  localparam int unsigned BYTE_W = 9;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input burst_ord_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_sram_front.sv
module zt_sram_front import zt_sram_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned CE_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [CE_N-1:0]   chip_en_i,
  input  logic              adv_i,
  input  logic              ilv_i,
  output logic              acc_valid_o,
  output logic              acc_we_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [BYTES-1:0]  acc_be_o
);

  logic              act_q;
  logic              we_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  burst_ord_e        ord_q;
  logic [BYTES-1:0]  be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      we_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      ord_q  <= ORD_LINEAR;
      be_q   <= '0;
    end else begin
      be_q <= be_i;
      if (!adv_i) begin
        act_q  <= &chip_en_i;
        we_q   <= we_i;
        base_q <= addr_i;
        cnt_q  <= '0;
        ord_q  <= burst_ord_e'(ilv_i);
      end else if (act_q) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign acc_valid_o = act_q;
  assign acc_we_o    = we_q;
  assign acc_be_o    = be_q;
  assign acc_addr_o  = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_q, ord_q)};

  AST_BURST_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && act_q) |=> (act_q && $stable(we_q) && $stable(base_q))); // R8
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R8
  AST_DESELECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !act_q) |=> !act_q); // R8

endmodule

// File: rtl/zt_sram_latewr.sv
module zt_sram_latewr import zt_sram_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DW    = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode_i,
  input  logic              par_odd_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [BYTES-1:0]  acc_be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              cm_valid_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [BYTES-1:0]  cm_be_o,
  output logic              par_err_o
);

  logic              d_valid_q;
  logic [ADDR_W-1:0] d_addr_q;
  logic [BYTES-1:0]  d_be_q;
  logic [BYTES-1:0]  bad_byte;
  logic              par_err_q;

  // Extra delay stage used only by the double late write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid_q <= 1'b0;
      d_addr_q  <= '0;
      d_be_q    <= '0;
    end else begin
      d_valid_q <= acc_valid_i & acc_we_i;
      d_addr_q  <= acc_addr_i;
      d_be_q    <= acc_be_i;
    end
  end

  assign cm_valid_o = pipe_mode_i ? d_valid_q : (acc_valid_i & acc_we_i);
  assign cm_addr_o  = pipe_mode_i ? d_addr_q  : acc_addr_i;
  assign cm_be_o    = pipe_mode_i ? d_be_q    : acc_be_i;

  for (genvar b = 0; b < BYTES; b++) begin : g_par
    assign bad_byte[b] = (^wdata_i[b*BYTE_W +: BYTE_W]) != par_odd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_err_q <= 1'b0;
    else        par_err_q <= cm_valid_o & (|(cm_be_o & bad_byte));
  end

  assign par_err_o = par_err_q;

  AST_PAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_o |-> $past(cm_valid_o)); // R11
  AST_DOUBLE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode_i && cm_valid_o) |-> $past(acc_valid_i && acc_we_i)); // R5

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array import zt_sram_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DW    = BYTES * BYTE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/zt_sram.sv
module zt_sram import zt_sram_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned CE_N   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we,
  input  logic [BYTES-1:0]        byte_en,
  input  logic [CE_N-1:0]         chip_en,
  input  logic                    adv,
  input  logic                    burst_ilv,
  input  logic                    pipe_mode,
  input  logic                    par_odd,
  input  logic                    oe_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    rdata_en,
  output logic                    par_err
);

  localparam int unsigned DW = BYTES * BYTE_W;

  logic              acc_valid;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [BYTES-1:0]  acc_be;
  logic              cm_valid;
  logic [ADDR_W-1:0] cm_addr;
  logic [BYTES-1:0]  cm_be;
  logic [DW-1:0]     arr_rd;
  logic [DW-1:0]     merged;
  logic              rd_now;
  logic              hit;
  logic              oq_valid;
  logic [DW-1:0]     oq_data;
  logic              sel_valid;
  logic [DW-1:0]     sel_data;

  zt_sram_front #(.ADDR_W(ADDR_W), .BYTES(BYTES), .CE_N(CE_N)) u_front (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .be_i(byte_en),
    .chip_en_i(chip_en), .adv_i(adv), .ilv_i(burst_ilv),
    .acc_valid_o(acc_valid), .acc_we_o(acc_we), .acc_addr_o(acc_addr), .acc_be_o(acc_be)
  );

  zt_sram_latewr #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_latewr (
    .clk(clk), .rst_n(rst_n), .pipe_mode_i(pipe_mode), .par_odd_i(par_odd),
    .acc_valid_i(acc_valid), .acc_we_i(acc_we), .acc_addr_i(acc_addr), .acc_be_i(acc_be),
    .wdata_i(wdata), .cm_valid_o(cm_valid), .cm_addr_o(cm_addr), .cm_be_o(cm_be),
    .par_err_o(par_err)
  );

  zt_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
    .clk(clk), .wr_en(cm_valid), .wr_addr(cm_addr), .wr_be(cm_be), .wr_data(wdata),
    .rd_addr(acc_addr), .rd_data(arr_rd)
  );

  // Bypass: write data landing on this edge overrides stale array bytes.
  assign rd_now = acc_valid & ~acc_we;
  assign hit    = cm_valid && (cm_addr == acc_addr);

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (hit && cm_be[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                          : arr_rd[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oq_valid <= 1'b0;
      oq_data  <= '0;
    end else begin
      oq_valid <= rd_now;
      oq_data  <= merged;
    end
  end

  assign sel_valid = pipe_mode ? oq_valid : rd_now;
  assign sel_data  = pipe_mode ? oq_data  : merged;
  assign rdata_en  = sel_valid & ~oe_n;
  assign rdata     = rdata_en ? sel_data : '0;

  AST_PIPE_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_now) |=> (rdata_en || oe_n)); // R3
  AST_FLOW_READ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_now && !oe_n) |-> rdata_en); // R4
  AST_OE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> (rdata == '0)); // R10

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [NB-1:0] byte_en = '0;
  logic [2:0]    chip_en = '0;
  logic          adv = 1'b0;
  logic          burst_ilv = 1'b0;
  logic          pipe_mode = 1'b1;
  logic          par_odd = 1'b0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_en;
  logic          par_err;

  zt_sram u_zt_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .byte_en(byte_en), .chip_en(chip_en),
    .adv(adv), .burst_ilv(burst_ilv), .pipe_mode(pipe_mode), .par_odd(par_odd), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .par_err(par_err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1234_abcd;

  // Reference model state
  logic [DW-1:0] mem_m [64];
  logic          op_v  [4];
  logic          op_we [4];
  logic [AW-1:0] op_a  [4];
  logic [NB-1:0] op_be [4];
  logic          m_act, m_we, m_ilv;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          exp_en, exp_par;
  logic [DW-1:0] exp_data;
  int            edge_n;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // Model of one clock edge, from the requirements.
  task automatic model_edge();
    int lat_w, lat_r, iw, ir, in;
    logic [1:0] lo;
    lat_w = pipe_mode ? 2 : 1;   // R5
    lat_r = pipe_mode ? 1 : 0;   // R3 / R4
    iw = (edge_n - lat_w) & 3;
    exp_par = 1'b0;
    if (op_v[iw] && op_we[iw]) begin
      for (int b = 0; b < NB; b++) begin
        if (op_be[iw][b]) begin   // R6
          mem_m[op_a[iw]][b*9 +: 9] = wdata[b*9 +: 9];
          if ((^wdata[b*9 +: 9]) != par_odd) exp_par = 1'b1;  // R11
        end
      end
    end
    in = edge_n & 3;
    if (!adv) begin               // R2
      m_act = &chip_en; m_we = we; m_base = addr; m_cnt = 2'd0; m_ilv = burst_ilv;
    end else if (m_act) begin     // R8
      m_cnt = m_cnt + 2'd1;
    end
    lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);  // R9
    op_v[in] = m_act; op_we[in] = m_we; op_a[in] = {m_base[AW-1:2], lo}; op_be[in] = byte_en;
    ir = (edge_n - lat_r) & 3;
    exp_en = op_v[ir] && !op_we[ir];
    exp_data = mem_m[op_a[ir]];   // R7 newest data
    edge_n++;
  endtask

  task automatic step(input logic [AW-1:0] a, input logic w, input logic [NB-1:0] be,
                      input logic [2:0] ce, input logic ad, input logic il,
                      input logic badp, input logic oe);
    logic [31:0] r;
    addr = a; we = w; byte_en = be; chip_en = ce; adv = ad; burst_ilv = il; oe_n = oe;
    r = rnd();
    for (int b = 0; b < NB; b++) begin
      wdata[b*9 +: 8] = r[b*8 +: 8];
      wdata[b*9 + 8]  = (^r[b*8 +: 8]) ^ par_odd ^ (badp && b == 0);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(exp_en ? (pipe_mode ? "R3" : "R4") : "R2", {31'd0, rdata_en}, {31'd0, exp_en & ~oe_n});
    if (exp_en && !oe_n) chk(pipe_mode ? "R3" : "R4", {14'd0, rdata}, {14'd0, exp_data});
    chk("R11", {31'd0, par_err}, {31'd0, exp_par});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(a, 1'b0, '0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic badp);
    step(a, 1'b1, be, 3'b111, 1'b0, 1'b0, badp, 1'b0);
  endtask

  // R10: asynchronous output disable between edges
  task automatic oe_pulse();
    oe_n = 1'b1;
    #2;
    chk("R10", {31'd0, rdata_en}, 32'd0);
    chk("R10", {14'd0, rdata}, 32'd0);
    oe_n = 1'b0;
    #1;
  endtask

  task automatic do_reset(input logic mode, input logic podd);
    rst_n = 1'b0;
    pipe_mode = mode; par_odd = podd;
    addr = '0; we = 0; byte_en = '0; chip_en = '0; adv = 0; oe_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R1", {31'd0, rdata_en}, 32'd0);
      chk("R1", {31'd0, par_err}, 32'd0);
    end
    for (int i = 0; i < 4; i++) begin
      op_v[i] = 0; op_we[i] = 0; op_a[i] = '0; op_be[i] = '0;
    end
    m_act = 0; m_we = 0; m_ilv = 0; m_base = '0; m_cnt = '0; edge_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_mode(input logic mode, input logic podd);
    logic [31:0] r;
    do_reset(mode, podd);
    idle(1);  // R1: nothing driven right after reset
    for (int i = 0; i < 64; i++) wr(i[AW-1:0], 2'b11, 1'b0);   // R6 fill
    idle(2);
    for (int i = 0; i < 16; i++) rd(i[AW-1:0]);
    idle(2);
    // R2: each missing chip enable blocks the write
    step(6'd5, 1'b1, 2'b11, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
    step(6'd5, 1'b1, 2'b11, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0);
    step(6'd5, 1'b1, 2'b11, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0);
    step(6'd5, 1'b0, 2'b00, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);
    rd(6'd5);
    idle(2);
    // R6: partial byte writes
    wr(6'd7, 2'b01, 1'b0); wr(6'd8, 2'b10, 1'b0); wr(6'd7, 2'b00, 1'b0);
    rd(6'd7); rd(6'd8);
    idle(2);
    // R7: write/read alternation on one address with pending data
    wr(6'd9, 2'b01, 1'b0); rd(6'd9); wr(6'd9, 2'b10, 1'b0); rd(6'd9); rd(6'd9);
    wr(6'd9, 2'b11, 1'b0); wr(6'd9, 2'b01, 1'b0); rd(6'd9); rd(6'd10);
    idle(2);
    // R8 / R9: bursts
    step(6'd10, 1'b1, 2'b11, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step('0, 1'b0, 2'b11, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0);
    step(6'd13, 1'b0, 2'b00, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step('0, 1'b1, 2'b11, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    step(6'd22, 1'b1, 2'b10, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step('0, 1'b0, 2'b11, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0);
    step(6'd21, 1'b0, 2'b00, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step('0, 1'b1, 2'b00, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8: advance after deselect stays idle
    step(6'd3, 1'b0, 2'b00, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step('0, 1'b0, 2'b00, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);
    // R10: output disable held, then pulsed between edges
    rd(6'd1);
    step(6'd2, 1'b0, 2'b00, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1);
    step(6'd3, 1'b0, 2'b00, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(6'd4); rd(6'd5);
    oe_pulse();
    rd(6'd6);
    idle(2);
    // R11: parity failures, including a disabled bad byte
    wr(6'd30, 2'b11, 1'b1); wr(6'd31, 2'b11, 1'b0); wr(6'd32, 2'b10, 1'b1); wr(6'd33, 2'b01, 1'b1);
    idle(3);
    rd(6'd30);
    idle(2);
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      r = rnd();
      step(r[5:0], r[6], r[8:7], (r[11:9] == 3'd0) ? r[14:12] : 3'b111,
           r[16:15] == 2'd0, r[17], r[21:18] == 4'd0, r[25:22] == 4'd0);
    end
    idle(4);
  endtask

  initial begin
    run_mode(1'b1, 1'b0);
    run_mode(1'b0, 1'b1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule